// File: doc/BRIEF.md
# Bidirectional Common Scan Register

This block is the scan path that a row driver uses when it runs in common mode. A shift register with one bit per output column advances on each falling edge of a line pulse. The register works either as one long chain, or as two independent chains of half its length. A direction input sets which way data travels. It also decides which of the two end pins takes the serial input and which one carries the serial output. In the split arrangement, a second serial input feeds the second chain, and a separate output carries that chain's last bit.

Each column also has a 2-bit level code. The code comes from the column's register bit and a frame-inversion input. An active-low display-off input blanks every code and empties the register.

The line pulse is treated as a signal that is sampled on the system clock. Each bidirectional end pin is split into three signals: a data input, a "driven" qualifier, and a data output with its output enable. An end pin that is in its input role but is not driven reads as 0, which models a pull-down.

Top module: `com_scan_reg`

## Requirements
- R1: The register changes only on the clock edge at which `lp_i` is sampled low after being sampled high on the previous edge. The new contents appear at the outputs right after that edge. On all other edges the register holds.
- R2: Single chain with `dir_i`=1 and `dual_i`=0. Data moves from column 1 toward column 160 and enters column 1 from end pin 1. `eio2_o` carries column 160, the bit just before it moves out.
- R3: Single chain with `dir_i`=0 and `dual_i`=0. Data moves from column 160 toward column 1 and enters column 160 from end pin 2. `eio1_o` carries column 1.
- R4: End-pin roles. With `dir_i`=1, pin 2 is the output (`eio2_oe_o`=1) and pin 1 is the input (`eio1_oe_o`=0). With `dir_i`=0, the roles are swapped. A pin in its input role drives 0 on its data output.
- R5: Split chains with `dir_i`=1 and `dual_i`=1. The first chain runs from column 1 to column 80, fed from pin 1, and its end bit (column 80) drives `eio2_o`. The second chain runs from column 81 to column 160, fed from `d7_i`, and `chain2_o` carries column 160. `chain2_o` is 0 when the register runs as a single chain.
- R6: Split chains with `dir_i`=0 and `dual_i`=1. The first chain runs from column 160 to column 81, fed from pin 2, and its end bit (column 81) drives `eio1_o`. The second chain runs from column 80 to column 1, fed from `d7_i`, and `chain2_o` carries column 1.
- R7: With `dispoff_n_i`=1, the code for column k+1 on `lvl_o[2k+1:2k]` is set by the frame input and that column's register bit. The codes are V0=3, V12=2, V43=1 and V5=0, and the mapping is:

  | frame | bit | level | code |
  |---|---|---|---|
  | 0 | 0 | V43 | 1 |
  | 0 | 1 | V0 | 3 |
  | 1 | 0 | V12 | 2 |
  | 1 | 1 | V5 | 0 |

- R8: Display-off (`dispoff_n_i`=0) has three effects:
  - Every code reads 0 in the same cycle.
  - The register is cleared on each clock edge while the input stays low.
  - Line-pulse falls are ignored.

  After release, shifting resumes at the next qualifying fall.
- R9: An end pin in its input role whose `_drv_i` qualifier is 0 shifts in 0, whatever its data input carries.
- R10: Reset (`rst_n`=0) clears the register and the line-pulse history. After reset, a low `lp_i` alone does not cause a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_i | input | 1 | Line pulse, sampled; the register shifts on its falling edge |
| dir_i | input | 1 | Direction: 1 moves data from column 1 upward, 0 moves it from column 160 downward |
| dual_i | input | 1 | 0 for one chain, 1 for two half-length chains |
| dispoff_n_i | input | 1 | Active-low display-off |
| frame_i | input | 1 | Frame-inversion input |
| eio1_i | input | 1 | End pin 1 input data |
| eio1_drv_i | input | 1 | End pin 1 is being driven from outside |
| eio1_o | output | 1 | End pin 1 output data |
| eio1_oe_o | output | 1 | End pin 1 output enable |
| eio2_i | input | 1 | End pin 2 input data |
| eio2_drv_i | input | 1 | End pin 2 is being driven from outside |
| eio2_o | output | 1 | End pin 2 output data |
| eio2_oe_o | output | 1 | End pin 2 output enable |
| d7_i | input | 1 | Serial input for the second chain in split mode |
| chain2_o | output | 1 | End bit of the second chain |
| lvl_o | output | 320 | Level code per column, two bits each, column 1 in the low bits |

## Verification
A shift becomes visible on the clock edge at which the low `lp_i` is first sampled. The register, the end-pin outputs and all level codes are therefore due one edge after the low pulse is applied. A change of `frame_i` or display-off alters the codes in the same cycle, and the register clear lands on the next edge. The bench applies every input just after a falling clock edge. The driver then computes the expected result from its own column model at the following rising edge and queues it. The monitor compares the queued result with the outputs at the next falling edge, half a cycle after the result became due and before any input moves again.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

   typedef logic [1:0] lvl_code_t;

   localparam lvl_code_t LVL_V0  = 2'd3;
   localparam lvl_code_t LVL_V12 = 2'd2;
   localparam lvl_code_t LVL_V43 = 2'd1;
   localparam lvl_code_t LVL_V5  = 2'd0;

   // common-mode level selection for one column
   function automatic lvl_code_t com_level(input logic frame, input logic on, input logic bit_v);
      lvl_code_t c;
      case ({frame, bit_v})
         2'b00:   c = LVL_V43;
         2'b01:   c = LVL_V0;
         2'b10:   c = LVL_V12;
         default: c = LVL_V5;
      endcase
      if (!on) c = LVL_V5;
      return c;
   endfunction

endpackage

// File: rtl/com_scan_edge.sv
module com_scan_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_i,
   output logic fall_o
);
   logic lp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lp_q <= 1'b0;
      else        lp_q <= lp_i;
   end

   assign fall_o = lp_q & ~lp_i;
endmodule

// File: rtl/com_scan_chain.sv
module com_scan_chain #(
   parameter int N       = 160,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         clear,
   input  logic         dir,
   input  logic         dual,
   input  logic         sin_a,
   input  logic         sin_b,
   output logic [N-1:0] q_o
);
   localparam int HALF = N / 2;

   logic [N-1:0] q;
   logic [N-1:0] nxt;

   for (genvar k = 0; k < N; k++) begin : g_bit
      logic up_src;
      logic dn_src;

      // upward chain: column 1 toward column N
      if (k == 0) begin : g_up_head
         assign up_src = sin_a;
      end else if (DUAL_EN && (k == HALF)) begin : g_up_split
         assign up_src = dual ? sin_b : q[k-1];
      end else begin : g_up_link
         assign up_src = q[k-1];
      end

      // downward chain: column N toward column 1
      if (k == N-1) begin : g_dn_head
         assign dn_src = sin_a;
      end else if (DUAL_EN && (k == HALF-1)) begin : g_dn_split
         assign dn_src = dual ? sin_b : q[k+1];
      end else begin : g_dn_link
         assign dn_src = q[k+1];
      end

      assign nxt[k] = dir ? up_src : dn_src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (clear)    q <= '0;
      else if (shift_en) q <= nxt;
   end

   assign q_o = q;
endmodule

// File: rtl/com_scan_level.sv
module com_scan_level
   import com_scan_pkg::*;
#(
   parameter int N = 160
) (
   input  logic           frame_i,
   input  logic           on_i,
   input  logic [N-1:0]   bits_i,
   output logic [2*N-1:0] lvl_o
);
   for (genvar k = 0; k < N; k++) begin : g_col
      assign lvl_o[2*k +: 2] = com_level(frame_i, on_i, bits_i[k]);
   end
endmodule

// File: rtl/com_scan_reg.sv
module com_scan_reg #(
   parameter int N_OUT   = 160,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lp_i,
   input  logic               dir_i,
   input  logic               dual_i,
   input  logic               dispoff_n_i,
   input  logic               frame_i,
   input  logic               eio1_i,
   input  logic               eio1_drv_i,
   output logic               eio1_o,
   output logic               eio1_oe_o,
   input  logic               eio2_i,
   input  logic               eio2_drv_i,
   output logic               eio2_o,
   output logic               eio2_oe_o,
   input  logic               d7_i,
   output logic               chain2_o,
   output logic [2*N_OUT-1:0] lvl_o
);
   localparam int HALF = N_OUT / 2;

   if ((N_OUT < 4) || (N_OUT % 2 != 0)) begin : g_bad_width
      $error("com_scan_reg: N_OUT must be even and at least 4");
   end

   logic             fall;
   logic             dual_eff;
   logic             sin_a;
   logic             shift_en;
   logic [N_OUT-1:0] sreg;
   logic             single_end;
   logic             first_end;
   logic             second_end;
   logic             ser_out;

   if (DUAL_EN) begin : g_dual
      assign dual_eff = dual_i;
   end else begin : g_single
      assign dual_eff = 1'b0;
   end

   com_scan_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lp_i  (lp_i),
      .fall_o(fall)
   );

   // input-role pin, undriven reads as 0
   assign sin_a    = dir_i ? (eio1_i & eio1_drv_i) : (eio2_i & eio2_drv_i);
   assign shift_en = fall & dispoff_n_i;

   com_scan_chain #(.N(N_OUT), .DUAL_EN(DUAL_EN)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .clear   (~dispoff_n_i),
      .dir     (dir_i),
      .dual    (dual_eff),
      .sin_a   (sin_a),
      .sin_b   (d7_i),
      .q_o     (sreg)
   );

   assign single_end = dir_i ? sreg[N_OUT-1] : sreg[0];
   assign first_end  = dir_i ? sreg[HALF-1]  : sreg[HALF];
   assign second_end = dir_i ? sreg[N_OUT-1] : sreg[0];
   assign ser_out    = dual_eff ? first_end : single_end;

   assign eio1_oe_o = ~dir_i;
   assign eio2_oe_o = dir_i;
   assign eio1_o    = ~dir_i & ser_out;
   assign eio2_o    = dir_i & ser_out;
   assign chain2_o  = dual_eff & second_end;

   com_scan_level #(.N(N_OUT)) u_level (
      .frame_i(frame_i),
      .on_i   (dispoff_n_i),
      .bits_i (sreg),
      .lvl_o  (lvl_o)
   );
endmodule

// File: rtl/com_scan_chk.sv
module com_scan_chk #(
   parameter int N       = 160,
   parameter bit DUAL_EN = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           lp_i,
   input logic           dir_i,
   input logic           dual_i,
   input logic           dispoff_n_i,
   input logic           frame_i,
   input logic           eio1_drv_i,
   input logic           eio1_o,
   input logic           eio1_oe_o,
   input logic           eio2_drv_i,
   input logic           eio2_o,
   input logic           eio2_oe_o,
   input logic           d7_i,
   input logic [N-1:0]   sreg,
   input logic [2*N-1:0] lvl_o
);
   localparam int HALF = N / 2;

   logic lp_seen;
   logic fall_c;

   always_ff @(posedge clk) begin
      if (!rst_n) lp_seen <= 1'b0;
      else        lp_seen <= lp_i;
   end
   assign fall_c = lp_seen & ~lp_i;

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dispoff_n_i && !fall_c) |=> $stable(sreg));

   p_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && dispoff_n_i && dir_i && !dual_i) |=> (eio2_o == $past(sreg[N-2])));

   p_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && dispoff_n_i && !dir_i && !dual_i) |=> (eio1_o == $past(sreg[1])));

   p_roles_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({eio1_oe_o, eio2_oe_o}) == 1) && (eio1_oe_o || !eio1_o) && (eio2_oe_o || !eio2_o));

   p_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_EN && fall_c && dispoff_n_i && dir_i && dual_i) |=> (sreg[HALF] == $past(d7_i)));

   p_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (DUAL_EN && fall_c && dispoff_n_i && !dir_i && dual_i) |=> (sreg[HALF-1] == $past(d7_i)));

   p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dispoff_n_i && !frame_i && sreg[0]) |-> (lvl_o[1:0] == 2'd3));

   p_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dispoff_n_i |-> (lvl_o == '0));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dispoff_n_i |=> (sreg == '0));

   p_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && dispoff_n_i && dir_i && !eio1_drv_i) |=> !sreg[0]);

   p_pull2_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && dispoff_n_i && !dir_i && !eio2_drv_i) |=> !sreg[N-1]);
endmodule

bind com_scan_reg com_scan_chk #(.N(N_OUT), .DUAL_EN(DUAL_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lp_i       (lp_i),
   .dir_i      (dir_i),
   .dual_i     (dual_i),
   .dispoff_n_i(dispoff_n_i),
   .frame_i    (frame_i),
   .eio1_drv_i (eio1_drv_i),
   .eio1_o     (eio1_o),
   .eio1_oe_o  (eio1_oe_o),
   .eio2_drv_i (eio2_drv_i),
   .eio2_o     (eio2_o),
   .eio2_oe_o  (eio2_oe_o),
   .d7_i       (d7_i),
   .sreg       (sreg),
   .lvl_o      (lvl_o)
);

// File: tb/sim_com_scan_reg.sv
module sim_com_scan_reg;
   localparam int N  = 160;
   localparam int H  = N / 2;
   localparam int EW = 2*N + 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_i = 1'b0, dir_i = 1'b1, dual_i = 1'b0, dispoff_n_i = 1'b1, frame_i = 1'b0;
   logic eio1_i = 1'b0, eio1_drv_i = 1'b0, eio2_i = 1'b0, eio2_drv_i = 1'b0, d7_i = 1'b0;
   logic eio1_o, eio1_oe_o, eio2_o, eio2_oe_o, chain2_o;
   logic [2*N-1:0] lvl_o;

   // staged next values, applied by the driver after a falling edge
   logic n_dir = 1'b1, n_dual = 1'b0, n_don = 1'b1, n_fr = 1'b0;
   logic n_e1 = 1'b0, n_e1drv = 1'b1, n_e2 = 1'b0, n_e2drv = 1'b1, n_d7 = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N-1:0] m = '0;
   logic         m_lp = 1'b0;

   logic [EW-1:0] exp_q[$];
   string         tag_q[$];

   always #4 clk = ~clk;

   com_scan_reg u0 (
      .clk(clk), .rst_n(rst_n), .lp_i(lp_i), .dir_i(dir_i), .dual_i(dual_i),
      .dispoff_n_i(dispoff_n_i), .frame_i(frame_i),
      .eio1_i(eio1_i), .eio1_drv_i(eio1_drv_i), .eio1_o(eio1_o), .eio1_oe_o(eio1_oe_o),
      .eio2_i(eio2_i), .eio2_drv_i(eio2_drv_i), .eio2_o(eio2_o), .eio2_oe_o(eio2_oe_o),
      .d7_i(d7_i), .chain2_o(chain2_o), .lvl_o(lvl_o)
   );

   function automatic logic [EW-1:0] expected();
      logic [2*N-1:0] lv;
      logic e1o, e2o, c2;
      for (int k = 0; k < N; k++) begin
         case ({frame_i, m[k]})
            2'b00:   lv[2*k +: 2] = 2'd1;
            2'b01:   lv[2*k +: 2] = 2'd3;
            2'b10:   lv[2*k +: 2] = 2'd2;
            default: lv[2*k +: 2] = 2'd0;
         endcase
         if (!dispoff_n_i) lv[2*k +: 2] = 2'd0;
      end
      e1o = !dir_i ? (dual_i ? m[H] : m[0]) : 1'b0;
      e2o = dir_i ? (dual_i ? m[H-1] : m[N-1]) : 1'b0;
      c2  = dual_i ? (dir_i ? m[N-1] : m[0]) : 1'b0;
      return {lv, e1o, !dir_i, e2o, dir_i, c2};
   endfunction

   task automatic model_edge();
      logic sa;
      logic fall;
      fall = m_lp & ~lp_i;
      sa = dir_i ? (eio1_i & eio1_drv_i) : (eio2_i & eio2_drv_i);
      if (!dispoff_n_i) m = '0;
      else if (fall) begin
         if (dir_i && !dual_i)      m = {m[N-2:0], sa};
         else if (!dir_i && !dual_i) m = {sa, m[N-1:1]};
         else if (dir_i) begin
            m[N-1:H] = {m[N-2:H], d7_i};
            m[H-1:0] = {m[H-2:0], sa};
         end else begin
            m[N-1:H] = {sa, m[N-1:H+1]};
            m[H-1:0] = {d7_i, m[H-1:1]};
         end
      end
      m_lp = lp_i;
   endtask

   task automatic step(input string tag, input logic lp);
      @(negedge clk); #1;
      lp_i = lp; dir_i = n_dir; dual_i = n_dual; dispoff_n_i = n_don; frame_i = n_fr;
      eio1_i = n_e1; eio1_drv_i = n_e1drv; eio2_i = n_e2; eio2_drv_i = n_e2drv; d7_i = n_d7;
      @(posedge clk);
      model_edge();
      exp_q.push_back(expected());
      tag_q.push_back(tag);
   endtask

   task automatic pulse(input string tag);
      step(tag, 1'b1);
      step(tag, 1'b0);
   endtask

   // monitor: compares half a cycle after each result is due
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [EW-1:0] e;
         logic [EW-1:0] a;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {lvl_o, eio1_o, eio1_oe_o, eio2_o, eio2_oe_o, chain2_o};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      step("R10", 1'b0);           // reset state, low pulse alone does not shift
      step("R7", 1'b0);

      // R1: only a fall shifts
      n_e1 = 1'b1;
      step("R1", 1'b1);
      step("R1", 1'b1);
      step("R1", 1'b0);
      step("R1", 1'b0);

      // R2: single chain upward
      for (int i = 0; i < 164; i++) begin
         n_e1 = (i % 3 == 0);
         pulse("R2");
      end

      // R9: pin 1 undriven reads as 0
      n_e1 = 1'b1; n_e1drv = 1'b0;
      for (int i = 0; i < 3; i++) pulse("R9");
      n_e1drv = 1'b1;

      // R4 and R3: downward single chain
      n_dir = 1'b0;
      step("R4", 1'b1);
      for (int i = 0; i < 164; i++) begin
         n_e2 = (i % 4 == 1);
         pulse("R3");
      end
      n_e2 = 1'b1; n_e2drv = 1'b0;
      for (int i = 0; i < 2; i++) pulse("R9");
      n_e2drv = 1'b1;

      // R5: split chains upward
      n_dir = 1'b1; n_dual = 1'b1;
      for (int i = 0; i < 84; i++) begin
         n_e1 = (i % 2 == 0);
         n_d7 = (i % 5 < 2);
         pulse("R5");
      end

      // R6: split chains downward
      n_dir = 1'b0;
      for (int i = 0; i < 84; i++) begin
         n_e2 = (i % 3 != 0);
         n_d7 = (i % 2 == 1);
         pulse("R6");
      end

      // R7: frame inversion on a mixed register
      n_fr = 1'b1; step("R7", 1'b1);
      n_fr = 1'b0; step("R7", 1'b1);

      // R8: display off blanks, clears, ignores falls, then resumes
      n_don = 1'b0;
      step("R8", 1'b1);
      step("R8", 1'b0);
      pulse("R8");
      n_don = 1'b1;
      step("R8", 1'b0);
      n_e2 = 1'b1; n_d7 = 1'b1;
      pulse("R8");
      pulse("R8");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule